// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Mixed Page Sizes

This block is a fully associative cache of address translations. Each slot maps a virtual page to a physical page and carries an address-space tag, a size class (base 4 KB page, 2 MB region or 1 GB region) and a small permission field. A lookup presents a virtual address together with the current address-space tag. One clock later the block reports either a hit with the physical address and permission, or a miss. A miss raises a refill trap so that privileged software can build the translation. Software then installs the translation through the write port. The block has no hardware table walker.

Software can install an entry into a slot it names, or let the block choose a slot in rotation. Stale translations are removed one at a time through a targeted invalidate, or all together through a flush. The response path is a three-state machine. `RS_IDLE` means no response this cycle, `RS_HIT` means a translation was found and `RS_MISS` means the refill trap is raised. Every cycle the machine moves to `RS_HIT` when a lookup is presented and some slot matches. It moves to `RS_MISS` when a lookup is presented and no slot matches. It returns to `RS_IDLE` when no lookup is presented. These moves apply from any state.

Top module: `tlbt_tagged`

## Requirements
- R1: The response to a lookup appears exactly one cycle after `lk_valid`, with `rsp_valid` high in that cycle. `rsp_valid` is low in the cycle after a cycle with no lookup.
- R2: On a hit for a 4 KB entry, `rsp_paddr` is the stored physical page number placed above the 12 low bits of the virtual address, and `rsp_perm` is the stored permission.
- R3: Size code 0 selects 4 KB, code 1 selects 2 MB and code 2 selects 1 GB. For 2 MB and 1 GB entries, virtual address bits below 21 and below 30 respectively are neither compared nor translated. They pass unchanged into `rsp_paddr`, and only the upper bits come from the stored physical page number.
- R4: A slot hits only when its stored tag equals `lk_pid`.
- R5: A miss gives `refill_trap`=1, `rsp_hit`=0 and `rsp_paddr`=0 in the response cycle.
- R6: A write with `wr_auto`=0 installs the entry into slot `wr_slot`, replacing any previous contents of that slot. Lookups see it from the next cycle.
- R7: A write with `wr_auto`=1 uses a rotating slot pointer. The pointer is 0 after reset, advances by one (wrapping after the last slot) only on such writes, and is unaffected by flush.
- R8: When several valid slots match a lookup, the lowest-numbered one supplies the translation and no error is signalled.
- R9: An invalidate removes every valid slot whose tag, size code and size-masked virtual page equal the request. A lookup in the same cycle still sees the old contents, and lookups from the next cycle miss. Slots that differ in any of the three fields are kept.
- R10: A flush clears every slot and overrides a write or invalidate in the same cycle. When a write and an invalidate fall in the same cycle, the write's slot ends up holding the new entry.
- R11: After reset all slots are empty and `rsp_valid`, `rsp_hit` and `refill_trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Current address-space tag |
| rsp_valid | output | 1 | Response present (one cycle after the lookup) |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | PA_W | Translated physical address, zero on miss |
| rsp_perm | output | PERM_W | Permission field of the hitting slot |
| refill_trap | output | 1 | Miss exception requesting software refill |
| wr_en | input | 1 | Install an entry |
| wr_auto | input | 1 | 1: rotating slot, 0: slot given by wr_slot |
| wr_slot | input | IDX_W | Explicit target slot |
| wr_vpn | input | VA_W-12 | Virtual page number |
| wr_ppn | input | PA_W-12 | Physical page number |
| wr_pid | input | PID_W | Address-space tag |
| wr_size | input | 2 | Size code (0 4 KB, 1 2 MB, 2 1 GB) |
| wr_perm | input | PERM_W | Permission field |
| inv_en | input | 1 | Targeted invalidate |
| inv_vpn | input | VA_W-12 | Virtual page to remove |
| inv_pid | input | PID_W | Tag to remove |
| inv_size | input | 2 | Size code to remove |
| flush | input | 1 | Clear every slot |

## Verification
The hardest situation to reach from the ports is a lookup that matches several slots of different sizes at once. It needs overlapping large and small entries under the same tag, alongside invalidates and writes that race with lookups. The random stimulus draws virtual page fields from a pool of four values per level and tags from four values. This makes overlapping 4 KB, 2 MB and 1 GB entries and duplicate slots common. Writes, invalidates and lookups are issued in the same cycles, so the ordering rules get exercised. Directed cases cover duplicate slots, the one-cycle invalidate latency, flush colliding with a write, and pointer wrap.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HIT  = 2'd1,
        RS_MISS = 2'd2
    } rsp_state_e;

    localparam int BASE_OFF = 12;
    localparam int MID_OFF  = 21;
    localparam int BIG_OFF  = 30;

    // number of untranslated low address bits for a size code
    function automatic int offset_of(logic [1:0] sz);
        case (sz)
            PG_2M:   return MID_OFF;
            PG_1G:   return BIG_OFF;
            default: return BASE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/tlbt_match_cell.sv
module tlbt_match_cell
    import tlbt_pkg::*;
#(
    parameter int VPN_W    = 28,
    parameter int PID_W    = 8,
    parameter bit USE_SIZE = 1'b0
) (
    input  logic             ent_valid,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [PID_W-1:0] ent_pid,
    input  logic [1:0]       ent_size,
    input  logic [VPN_W-1:0] key_vpn,
    input  logic [PID_W-1:0] key_pid,
    input  logic [1:0]       key_size,
    output logic             match
);
    logic [VPN_W-1:0] cmp_mask;
    logic             size_ok;

    always_comb begin
        for (int i = 0; i < VPN_W; i++) begin
            cmp_mask[i] = (i + BASE_OFF) >= offset_of(ent_size);
        end
    end

    assign size_ok = USE_SIZE ? (ent_size == key_size) : 1'b1;
    assign match   = ent_valid && size_ok && (ent_pid == key_pid)
                     && (((ent_vpn ^ key_vpn) & cmp_mask) == '0);

endmodule

// File: rtl/tlbt_first_hit.sv
module tlbt_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbt_tagged.sv
module tlbt_tagged
    import tlbt_pkg::*;
#(
    parameter int VA_W    = 40,
    parameter int PA_W    = 40,
    parameter int PID_W   = 8,
    parameter int PERM_W  = 3,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VPN_W  = VA_W - BASE_OFF,
    localparam int PPN_W  = PA_W - BASE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              refill_trap,
    input  logic              wr_en,
    input  logic              wr_auto,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [1:0]        wr_size,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic [PID_W-1:0]  inv_pid,
    input  logic [1:0]        inv_size,
    input  logic              flush
);
    // slot storage
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [PID_W-1:0]   pid_q  [ENTRIES];
    logic [1:0]         size_q [ENTRIES];
    logic [PERM_W-1:0]  perm_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] inv_hit_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   sel_idx;
    logic [IDX_W-1:0]   wr_target;
    logic [VPN_W-1:0]   lk_vpn;

    assign lk_vpn    = lk_vaddr[VA_W-1:BASE_OFF];
    assign wr_target = wr_auto ? rr_q : wr_slot;

    // one lookup comparator and one invalidate comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlbt_match_cell #(.VPN_W(VPN_W), .PID_W(PID_W), .USE_SIZE(1'b0)) u_lk (
            .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_pid(pid_q[g]),
            .ent_size(size_q[g]), .key_vpn(lk_vpn), .key_pid(lk_pid),
            .key_size(2'd0), .match(lk_hit_vec[g])
        );
        tlbt_match_cell #(.VPN_W(VPN_W), .PID_W(PID_W), .USE_SIZE(1'b1)) u_inv (
            .ent_valid(valid_q[g]), .ent_vpn(vpn_q[g]), .ent_pid(pid_q[g]),
            .ent_size(size_q[g]), .key_vpn(inv_vpn), .key_pid(inv_pid),
            .key_size(inv_size), .match(inv_hit_vec[g])
        );

        always_ff @(posedge clk) begin
            if (wr_en && !flush && wr_target == IDX_W'(g)) begin
                vpn_q[g]  <= wr_vpn;
                ppn_q[g]  <= wr_ppn;
                pid_q[g]  <= wr_pid;
                size_q[g] <= wr_size;
                perm_q[g] <= wr_perm;
            end
        end
    end

    tlbt_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
        .req(lk_hit_vec), .any(lk_any), .idx(sel_idx)
    );

    // valid bits and rotating pointer: flush > write > invalidate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            if (flush) begin
                valid_q <= '0;
            end else begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (wr_en && wr_target == IDX_W'(e)) begin
                        valid_q[e] <= 1'b1;
                    end else if (inv_en && inv_hit_vec[e]) begin
                        valid_q[e] <= 1'b0;
                    end
                end
                if (wr_en && wr_auto) begin
                    rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
                end
            end
        end
    end

    // physical address composition for the selected slot
    logic [PA_W-1:0] lk_pa;
    logic [PA_W-1:0] base_pa;
    logic [PA_W-1:0] va_ext;
    int              sel_off;

    always_comb begin
        sel_off = offset_of(size_q[sel_idx]);
        base_pa = {ppn_q[sel_idx], {BASE_OFF{1'b0}}};
        va_ext  = PA_W'(lk_vaddr);
        for (int b = 0; b < PA_W; b++) begin
            lk_pa[b] = (b < sel_off) ? va_ext[b] : base_pa[b];
        end
    end

    // response state machine
    rsp_state_e        state_q, state_d;
    logic [PA_W-1:0]   paddr_q;
    logic [PERM_W-1:0] perm_out_q;

    always_comb begin
        if (!lk_valid)   state_d = RS_IDLE;
        else if (lk_any) state_d = RS_HIT;
        else             state_d = RS_MISS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            paddr_q    <= '0;
            perm_out_q <= '0;
        end else begin
            state_q    <= state_d;
            paddr_q    <= (state_d == RS_HIT) ? lk_pa : '0;
            perm_out_q <= (state_d == RS_HIT) ? perm_q[sel_idx] : '0;
        end
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_hit     = 1'b0;
        refill_trap = 1'b0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT:  begin rsp_valid = 1'b1; rsp_hit = 1'b1; end
            RS_MISS: begin rsp_valid = 1'b1; refill_trap = 1'b1; end
            default: ;
        endcase
        rsp_paddr = paddr_q;
        rsp_perm  = perm_out_q;
    end

    // assertions
    p_resp_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_resp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    p_miss_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refill_trap |-> (!rsp_hit && rsp_paddr == '0));
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_any |-> (lk_hit_vec[sel_idx]
                    && ((lk_hit_vec & ~({ENTRIES{1'b1}} << sel_idx)) == '0)));
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    p_inv_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !wr_en && !flush) |=> ((valid_q & $past(inv_hit_vec)) == '0));
    p_rr_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_auto && !flush) |=> valid_q[$past(rr_q)]);

endmodule

// File: tb/tlbt_tagged_test.sv
module tlbt_tagged_test;
    localparam int VA_W = 40, PA_W = 40, PID_W = 8, PERM_W = 3, N = 16;
    localparam int VPN_W = VA_W - 12, PPN_W = PA_W - 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              lk_valid = 0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [PID_W-1:0]  lk_pid = '0;
    logic              rsp_valid, rsp_hit, refill_trap;
    logic [PA_W-1:0]   rsp_paddr;
    logic [PERM_W-1:0] rsp_perm;
    logic              wr_en = 0, wr_auto = 0;
    logic [3:0]        wr_slot = '0;
    logic [VPN_W-1:0]  wr_vpn = '0;
    logic [PPN_W-1:0]  wr_ppn = '0;
    logic [PID_W-1:0]  wr_pid = '0;
    logic [1:0]        wr_size = '0;
    logic [PERM_W-1:0] wr_perm = '0;
    logic              inv_en = 0;
    logic [VPN_W-1:0]  inv_vpn = '0;
    logic [PID_W-1:0]  inv_pid = '0;
    logic [1:0]        inv_size = '0;
    logic              flush = 0;

    tlbt_tagged uut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // reference model of the slot table
    bit               m_valid [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [PPN_W-1:0] m_ppn [N];
    logic [PID_W-1:0] m_pid [N];
    logic [1:0]       m_size [N];
    logic [PERM_W-1:0] m_perm [N];
    int               m_rr = 0;

    function automatic int offs(logic [1:0] s);
        return (s == 2'd1) ? 21 : (s == 2'd2) ? 30 : 12;
    endfunction

    function automatic bit vmatch(int e, logic [VPN_W-1:0] v, logic [PID_W-1:0] p);
        logic [VA_W-1:0] a, b, msk;
        a = {m_vpn[e], 12'h0};
        b = {v, 12'h0};
        msk = ~((40'd1 << offs(m_size[e])) - 40'd1);
        return m_valid[e] && m_pid[e] == p && ((a ^ b) & msk) == '0;
    endfunction

    bit               e_hit;
    logic [PA_W-1:0]  e_pa;
    logic [PERM_W-1:0] e_perm;

    task automatic model_lookup(logic [VA_W-1:0] va, logic [PID_W-1:0] p);
        logic [PA_W-1:0] lo;
        e_hit = 0; e_pa = '0; e_perm = '0;
        for (int e = 0; e < N; e++) begin
            if (!e_hit && vmatch(e, va[VA_W-1:12], p)) begin
                e_hit = 1;
                lo = (40'd1 << offs(m_size[e])) - 40'd1;
                e_pa = ({m_ppn[e], 12'h0} & ~lo) | (va & lo);
                e_perm = m_perm[e];
            end
        end
    endtask

    task automatic model_update();
        bit ih [N];
        int tgt;
        if (flush) begin
            for (int e = 0; e < N; e++) m_valid[e] = 0;
            return;
        end
        for (int e = 0; e < N; e++)
            ih[e] = inv_en && vmatch(e, inv_vpn, inv_pid) && m_size[e] == inv_size;
        for (int e = 0; e < N; e++) if (ih[e]) m_valid[e] = 0;
        if (wr_en) begin
            tgt = wr_auto ? m_rr : int'(wr_slot);
            m_valid[tgt] = 1; m_vpn[tgt] = wr_vpn; m_ppn[tgt] = wr_ppn;
            m_pid[tgt] = wr_pid; m_size[tgt] = wr_size; m_perm[tgt] = wr_perm;
            if (wr_auto) m_rr = (m_rr + 1) % N;
        end
    endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: inputs already set; checks the response after the edge
    task automatic step(string req);
        bit was_lk;
        was_lk = lk_valid;
        if (lk_valid) model_lookup(lk_vaddr, lk_pid);
        @(posedge clk); #1;
        model_update();
        check(rsp_valid == was_lk, {req, " R1 valid"}, 64'(rsp_valid), 64'(was_lk));
        if (was_lk) begin
            check(rsp_hit == e_hit, {req, " hit"}, 64'(rsp_hit), 64'(e_hit));
            check(refill_trap == !e_hit, {req, " R5 trap"}, 64'(refill_trap), 64'(!e_hit));
            check(rsp_paddr == e_pa, {req, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
            if (e_hit) check(rsp_perm == e_perm, {req, " perm"}, 64'(rsp_perm), 64'(e_perm));
        end
        lk_valid = 0; wr_en = 0; inv_en = 0; flush = 0; wr_auto = 0;
    endtask

    task automatic put(bit au, int slot, logic [VPN_W-1:0] v, logic [PPN_W-1:0] pp,
                       logic [PID_W-1:0] p, logic [1:0] s, logic [PERM_W-1:0] pm);
        wr_en = 1; wr_auto = au; wr_slot = 4'(slot); wr_vpn = v; wr_ppn = pp;
        wr_pid = p; wr_size = s; wr_perm = pm;
    endtask

    task automatic look(logic [VA_W-1:0] va, logic [PID_W-1:0] p);
        lk_valid = 1; lk_vaddr = va; lk_pid = p;
    endtask

    function automatic logic [VPN_W-1:0] rvpn();
        return {10'($urandom % 4), 9'($urandom % 4), 9'($urandom % 4)};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int e = 0; e < N; e++) begin
            m_valid[e] = 0; m_vpn[e] = '0; m_ppn[e] = '0;
            m_pid[e] = '0; m_size[e] = '0; m_perm[e] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(!rsp_valid && !rsp_hit && !refill_trap, "R11 reset outputs",
              64'({rsp_valid, rsp_hit, refill_trap}), 64'd0);
        rst_n = 1;
        @(posedge clk); #1;

        // R11: empty after reset
        look(40'h12_3456_7000, 8'd5); step("R11 empty miss");
        check(refill_trap == 1, "R11 R5 trap after reset", 64'(refill_trap), 64'd1);

        // R6 / R2: explicit slot write, 4 KB hit
        put(0, 3, 28'h0012345, 28'h00ABCDE, 8'd5, 2'd0, 3'd5); step("R6 write");
        look(40'h00_1234_5678, 8'd5); step("R2 4K hit");
        check(rsp_paddr == 40'h00_ABCD_E678, "R2 literal pa", 64'(rsp_paddr), 64'h00ABCDE678);
        check(rsp_perm == 3'd5, "R2 literal perm", 64'(rsp_perm), 64'd5);
        // R4: wrong tag
        look(40'h00_1234_5678, 8'd6); step("R4 pid mismatch");
        check(refill_trap == 1, "R4 trap on other pid", 64'(refill_trap), 64'd1);
        // R1: idle cycle
        step("R1 idle");

        // R3: 2 MB and 1 GB regions
        put(0, 4, 28'h0400200, 28'h0800000, 8'd1, 2'd1, 3'd3); step("R3 write 2M");
        look(40'h04_0021_ABCD, 8'd1); step("R3 2M hit");
        check(rsp_paddr == 40'h08_0001_ABCD, "R3 2M literal pa", 64'(rsp_paddr), 64'h080001ABCD);
        put(0, 5, 28'h3000000, 28'h1400000, 8'd2, 2'd2, 3'd1); step("R3 write 1G");
        look(40'h30_2345_6789, 8'd2); step("R3 1G hit");
        check(rsp_paddr == 40'h14_2345_6789, "R3 1G literal pa", 64'(rsp_paddr), 64'h1423456789);

        // R8: duplicate slots, lowest index wins
        put(0, 7, 28'h0055555, 28'h0000077, 8'd9, 2'd0, 3'd7); step("R8 write hi");
        put(0, 1, 28'h0055555, 28'h0000011, 8'd9, 2'd0, 3'd2); step("R8 write lo");
        look(40'h00_5555_5000, 8'd9); step("R8 priority");
        check(rsp_paddr == 40'h00_0001_1000, "R8 lowest slot", 64'(rsp_paddr), 64'h0000011000);

        // R9: wrong size leaves entry, right key removes it next cycle
        inv_en = 1; inv_vpn = 28'h0012345; inv_pid = 8'd5; inv_size = 2'd1; step("R9 wrong size");
        look(40'h00_1234_5000, 8'd5); step("R9 kept");
        check(rsp_hit == 1, "R9 kept hit", 64'(rsp_hit), 64'd1);
        inv_en = 1; inv_size = 2'd0; look(40'h00_1234_5000, 8'd5); step("R9 same cycle");
        check(rsp_hit == 1, "R9 same cycle old view", 64'(rsp_hit), 64'd1);
        look(40'h00_1234_5000, 8'd5); step("R9 next cycle");
        check(rsp_hit == 0, "R9 removed", 64'(rsp_hit), 64'd0);

        // R10: flush beats write; write beats invalidate
        put(0, 9, 28'h0066666, 28'h1, 8'd3, 2'd0, 3'd0); flush = 1; step("R10 flush+write");
        look(40'h00_6666_6000, 8'd3); step("R10 dropped write");
        check(rsp_hit == 0, "R10 flush wins", 64'(rsp_hit), 64'd0);
        look(40'h04_0021_0000, 8'd1); step("R10 flushed 2M");
        put(0, 2, 28'h0077777, 28'h2, 8'd3, 2'd0, 3'd0); step("R10 seed");
        put(0, 2, 28'h0077777, 28'h5, 8'd3, 2'd0, 3'd4);
        inv_en = 1; inv_vpn = 28'h0077777; inv_pid = 8'd3; inv_size = 2'd0; step("R10 wr+inv");
        look(40'h00_7777_7000, 8'd3); step("R10 write wins");
        check(rsp_hit == 1, "R10 write over inv", 64'(rsp_hit), 64'd1);

        // R7: 17 rotating writes wrap onto the first slot
        for (int k = 0; k < N + 1; k++) begin
            put(1, 0, 28'h0100000 + 28'(k), 28'h0200000 + 28'(k), 8'd4, 2'd0, 3'd1);
            step("R7 auto write");
        end
        look({28'h0100000, 12'h0}, 8'd4); step("R7 first overwritten");
        check(rsp_hit == 0, "R7 wrap evicts", 64'(rsp_hit), 64'd0);
        look({28'h0100001, 12'h0}, 8'd4); step("R7 second kept");
        check(rsp_hit == 1, "R7 second kept", 64'(rsp_hit), 64'd1);

        // mixed random traffic
        for (int t = 0; t < 2000; t++) begin
            if ($urandom % 4 == 0)
                put($urandom % 2 == 1, int'($urandom % N), rvpn(), 28'($urandom),
                    8'($urandom % 4), 2'($urandom % 3), 3'($urandom));
            if ($urandom % 10 == 0) begin
                inv_en = 1; inv_vpn = rvpn(); inv_pid = 8'($urandom % 4);
                inv_size = 2'($urandom % 3);
            end
            if ($urandom % 50 == 0) flush = 1;
            if ($urandom % 8 != 0) look({rvpn(), 12'($urandom)}, 8'($urandom % 4));
            step("R3 R4 R8 R9 R10 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule